// File: doc/BRIEF.md
# Program-Busy Read Status Overlay

This block sits on the read path of a word-wide non-volatile memory. While an internal program or erase operation runs, it replaces the word returned to the host with status information. The host can then poll the memory and tell when the operation has finished. When no operation is running, the array's read data passes through untouched.

Two status methods work together, and each byte lane carries both of them. The top bit of each byte returns the inverse of the matching bit of the word that was loaded last. When the operation ends, that bit shows the true stored value again. The bit below it flips on every new read. A new read is counted when chip select and output enable, both active low, become jointly active. Cycling either one of them starts a new read.

A single toggle register feeds both byte lanes. Its starting value carries no meaning; only its alternation between reads is defined.

Top module: `rd_status_mux`

## Requirements
- R1: While busy_i is low, rd_data_o equals array_data_i on all 16 bits.
- R2: While busy_i is high, rd_data_o bits 7 and 15 equal the inverse of last_word_i bits 7 and 15.
- R3: While busy_i is high, rd_data_o bits 0 to 5 and 8 to 13 equal the same bits of last_word_i.
- R4: While busy_i is high, rd_data_o bits 6 and 14 are always equal to each other.
- R5: While busy_i is high, each new read flips bits 6 and 14 once. A new read is ce_n and oe_n becoming both low after at least one of them was high. The flip is visible from the cycle after the first clock edge that samples the read.
- R6: A new read started by cycling oe_n alone and one started by cycling ce_n alone each cause the flip of R5.
- R7: While busy_i is high, a read held active across many cycles, or no read at all, leaves bits 6 and 14 unchanged.
- R8: When busy_i falls, bits 6, 7, 14 and 15 return array data in the same cycle, with no toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | High while an internal program or erase operation runs |
| last_word_i | input | 16 | Word loaded last before the operation started |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data_i | input | 16 | Normal read data from the array |
| rd_data_o | output | 16 | Read data with status overlay |

## Verification
A stuck or double-stepping toggle register shows at the ports on the very next read: two reads in a row return the same bit 6, or bits 6 and 14 disagree. A broken read-edge detector that misses one of the two enables, or that counts a held read more than once, shows within a cycle of that stimulus. Faults in the mux selection or the inversion show combinationally in the same cycle that busy_i or last_word_i changes.

// File: rtl/rd_status_mux.sv
module rd_status_mux #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic [DW-1:0] last_word_i,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] array_data_i,
  output logic [DW-1:0] rd_data_o
);

  localparam int NB = DW / 8;

  logic          rd_act;
  logic          rd_act_q;
  logic          tgl_q;
  logic [DW-1:0] stat_word;

  assign rd_act = ~ce_n & ~oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      tgl_q    <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      if (busy_i && rd_act && !rd_act_q)
        tgl_q <= ~tgl_q;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign stat_word[b*8 +: 6] = last_word_i[b*8 +: 6];
    assign stat_word[b*8 + 6]  = tgl_q;
    assign stat_word[b*8 + 7]  = ~last_word_i[b*8 + 7];
  end

  assign rd_data_o = busy_i ? stat_word : array_data_i;

endmodule

module rd_status_mux_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic [DW-1:0] last_word_i,
  input logic          ce_n,
  input logic          oe_n,
  input logic [DW-1:0] array_data_i,
  input logic [DW-1:0] rd_data_o
);
  logic act, act_q, new_rd;
  assign act    = !ce_n && !oe_n;
  assign new_rd = act && !act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy_i |-> rd_data_o == array_data_i); // R1
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n) busy_i |-> (rd_data_o[7] != last_word_i[7]) && (rd_data_o[15] != last_word_i[15])); // R2
  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n) busy_i |-> (rd_data_o[5:0] == last_word_i[5:0]) && (rd_data_o[13:8] == last_word_i[13:8])); // R3
  AST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n) busy_i |-> rd_data_o[6] == rd_data_o[14]); // R4
  AST_FLIP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && new_rd) |=> (!busy_i || rd_data_o[6] != $past(rd_data_o[6]))); // R5
  AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && !new_rd) |=> (!busy_i || $stable(rd_data_o[6]))); // R7
endmodule

bind rd_status_mux rd_status_mux_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .last_word_i(last_word_i),
  .ce_n(ce_n), .oe_n(oe_n), .array_data_i(array_data_i), .rd_data_o(rd_data_o)
);

// File: tb/sim_rd_status_mux.sv
`timescale 1ns/1ps
module sim_rd_status_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy_i = 1'b0;
  logic [15:0] last_word_i = 16'h0000;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [15:0] array_data_i = 16'h0000;
  logic [15:0] rd_data_o;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rd_status_mux u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] stat(input logic [15:0] lw, input logic t);
    stat = {~lw[15], t, lw[13:8], ~lw[7], t, lw[5:0]};
  endfunction

  // read by pulsing oe_n with ce_n held low; returns sampled word
  task automatic rd_oe(output logic [15:0] d);
    ce_n = 1'b0; oe_n = 1'b0; tick(2); d = rd_data_o; oe_n = 1'b1; tick(2);
  endtask

  task automatic rd_ce(output logic [15:0] d);
    oe_n = 1'b0; ce_n = 1'b0; tick(2); d = rd_data_o; ce_n = 1'b1; tick(2);
  endtask

  task automatic t_reset;
    array_data_i = 16'hC3A5; tick(1);
    chk("R1 reset pass", rd_data_o, 16'hC3A5);
  endtask

  task automatic t_idle;
    logic [15:0] d;
    foreach (d[i]) ;
    array_data_i = 16'hFFFF; tick(1); chk("R1 idle ffff", rd_data_o, 16'hFFFF);
    array_data_i = 16'h4040; rd_oe(d); chk("R1 idle read", d, 16'h4040);
    array_data_i = 16'h8181; tick(1); chk("R1 idle 8181", rd_data_o, 16'h8181);
  endtask

  task automatic t_poll;
    logic [15:0] d;
    logic t0;
    busy_i = 1'b1; array_data_i = 16'h1234;
    last_word_i = 16'h8080; tick(1); t0 = rd_data_o[6];
    chk("R2 poll 8080", rd_data_o, stat(16'h8080, t0));
    last_word_i = 16'h3F3F; tick(1);
    chk("R2 R3 poll 3f3f", rd_data_o, stat(16'h3F3F, t0));
    last_word_i = 16'h5A2D; tick(1);
    chk("R3 other bits", rd_data_o, stat(16'h5A2D, t0));
    chk("R4 lanes equal", {15'd0, rd_data_o[6]}, {15'd0, rd_data_o[14]});
  endtask

  task automatic t_toggle_oe;
    logic [15:0] a, b, c;
    rd_oe(a); rd_oe(b); rd_oe(c);
    chk("R5 oe flip 1", {15'd0, b[6]}, {15'd0, ~a[6]});
    chk("R5 oe flip 2", {15'd0, c[6]}, {15'd0, a[6]});
    chk("R4 lanes after reads", {15'd0, c[14]}, {15'd0, c[6]});
  endtask

  task automatic t_toggle_ce;
    logic [15:0] a, b;
    rd_ce(a); rd_ce(b);
    chk("R6 ce flip", {15'd0, b[6]}, {15'd0, ~a[6]});
    oe_n = 1'b1; ce_n = 1'b1; tick(1);
    rd_oe(a); rd_ce(b);
    chk("R6 oe then ce", {15'd0, b[6]}, {15'd0, ~a[6]});
  endtask

  task automatic t_hold;
    logic [15:0] a;
    logic t0;
    oe_n = 1'b1; ce_n = 1'b0; tick(2); t0 = rd_data_o[6];
    tick(5); chk("R7 no read stable", {15'd0, rd_data_o[6]}, {15'd0, t0});
    oe_n = 1'b0; tick(2); a = rd_data_o;
    tick(8); chk("R7 held read stable", {15'd0, rd_data_o[6]}, {15'd0, a[6]});
    chk("R5 held read flipped once", {15'd0, a[6]}, {15'd0, ~t0});
    oe_n = 1'b1; tick(2);
  endtask

  task automatic t_done;
    last_word_i = 16'h8080; array_data_i = 16'hC0C0;
    tick(1); busy_i = 1'b0; #0.5;
    chk("R8 done same cycle", rd_data_o, 16'hC0C0);
    tick(1); chk("R8 done true data", rd_data_o, 16'hC0C0);
    array_data_i = 16'h0000; tick(1);
    chk("R8 done bits clear", rd_data_o, 16'h0000);
  endtask

  initial begin
    fork
      begin
        tick(3); rst_n = 1'b1; tick(1);
        t_reset(); t_idle(); t_poll(); t_toggle_oe(); t_toggle_ce(); t_hold(); t_done();
      end
      begin
        tick(20000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule